// File: doc/BRIEF.md
# Serial Register Readback Slave

This block is the readback side of the serial port of a dual-channel converter. A host frames each transfer with an active-low chip select and clocks it with a serial clock. Bits are captured and launched on serial-clock falling edges, MSB first. During one frame the host sends a 16-bit request naming one of three registers: the configuration word or one of the two reference-DAC codes. In the next frame the block returns that register on the first data output. The second data output stays low.

Serial clock, chip select and data-in are brought into the system clock through two-stage synchronizers, and all edges are detected in that domain. A frame counts only if it has at least 48 serial-clock falling edges. A shorter frame is dropped without any effect. The three registers are loaded from a parallel write port into a staging copy. The staged values reach the active copy only at the end of a full-length frame, so a value written during one frame is seen from the next frame onward.

Top module: `rbk_serial_slave`

## Requirements
- R1: The request is the first 16 bits captured in a frame, MSB first. Bits 15:12 select the register: 0011 is the configuration register, 0001 is reference DAC A and 0010 is reference DAC B. Any other selector, or any nonzero bit in 11:0, arms no readback.
- R2: A frame that ends with fewer than 48 serial-clock falling edges is discarded. It arms no readback and commits no staged register value.
- R3: In the frame after an accepted request, sdo_a carries readback bit 15 after falling edge 1 and bit 0 after falling edge 16. After every later falling edge of that frame it is 0.
- R4: sdo_b is 0 at all times.
- R5: The configuration readback word is the selector 0011 in bits 15:12, followed by configuration bits 11:0.
- R6: A DAC readback word is its selector in bits 15:12 and the 9-bit code in bits 11:3 (code bit 8 in bit 11), with bits 2:0 zero.
- R7: A write from the port (wr_sel 0 = configuration, 1 = DAC A, 2 = DAC B, 3 = ignored; a DAC takes wr_data[8:0]) is staged. The staged value becomes visible only at the end of the next frame that has at least 48 edges. A write made during a readback frame does not change that frame's output.
- R8: After reset all three registers are zero and both outputs are low.
- R9: A request is delivered only in the frame directly after it. The frame after that returns zeros unless it was itself preceded by a new request.
- R10: sdo_a changes only on a serial-clock falling edge inside a frame, and it is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock, idle high |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial request data |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 config, 1 DAC A, 2 DAC B |
| wr_data_i | input | 12 | Write value (DAC uses bits 8:0) |
| sdo_a_o | output | 1 | Readback data line |
| sdo_b_o | output | 1 | Second data line, held low |

## Verification
The hardest case to reach is the one-frame deferral of register updates. A write has to arrive while a readback frame is in flight. The bench must then show that the frame still returns the value committed at the end of the earlier full-length frame, and that the new value appears only one request later. The bench reaches this by issuing the write from inside the frame task at a fixed falling edge, during both the request frame and the readback frame. It then follows with a second request and readback pair. Short 47-edge frames and 64-edge frames from the vector table cover the minimum-length rule on both sides of the limit.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
    localparam int WORD_W = 16;
    localparam int CFG_W  = 12;
    localparam int DAC_W  = 9;

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_DACA = 2'd1,
        REG_DACB = 2'd2,
        REG_NONE = 2'd3
    } reg_id_e;

    localparam logic [3:0] CODE_CFG  = 4'b0011;
    localparam logic [3:0] CODE_DACA = 4'b0001;
    localparam logic [3:0] CODE_DACB = 4'b0010;

    function automatic reg_id_e decode_req(input logic [WORD_W-1:0] w);
        reg_id_e id;
        id = REG_NONE;
        if (w[11:0] == 12'h000) begin
            case (w[15:12])
                CODE_CFG:  id = REG_CFG;
                CODE_DACA: id = REG_DACA;
                CODE_DACB: id = REG_DACB;
                default:   id = REG_NONE;
            endcase
        end
        return id;
    endfunction

    function automatic logic [WORD_W-1:0] fmt_word(input reg_id_e id,
                                                   input logic [CFG_W-1:0] cfg,
                                                   input logic [DAC_W-1:0] dac_a,
                                                   input logic [DAC_W-1:0] dac_b);
        logic [WORD_W-1:0] w;
        case (id)
            REG_CFG:  w = {CODE_CFG, cfg};
            REG_DACA: w = {CODE_DACA, dac_a, 3'b000};
            REG_DACB: w = {CODE_DACB, dac_b, 3'b000};
            default:  w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/rbk_sync.sv
module rbk_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                s_q.chain[i] <= RST_VAL;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/rbk_frame_ctrl.sv
module rbk_frame_ctrl
    import rbk_pkg::*;
#(
    parameter int MIN_EDGES = 48,
    parameter int REQ_BITS  = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    csn_s,
    input  logic    sclk_s,
    input  logic    sdi_s,
    output logic    in_frame_o,
    output logic    sclk_fall_o,
    output logic    start_o,
    output logic    end_o,
    output logic    commit_o,
    output logic    load_valid_o,
    output reg_id_e load_sel_o
);
    localparam int CNT_W = $clog2(MIN_EDGES + 1);

    typedef struct packed {
        logic                in_frame;
        logic                csn_prev;
        logic                sclk_prev;
        logic [CNT_W-1:0]    cnt;
        logic [REQ_BITS-1:0] rx;
        logic                armed;
        reg_id_e             sel;
    } fc_t;

    fc_t f_d, f_q;
    logic cs_fall, cs_rise, sclk_fall, long_enough;
    reg_id_e dec_id;

    always_comb begin
        cs_fall     = f_q.csn_prev & ~csn_s;
        cs_rise     = ~f_q.csn_prev & csn_s;
        sclk_fall   = f_q.sclk_prev & ~sclk_s;
        long_enough = (f_q.cnt >= CNT_W'(MIN_EDGES));
        dec_id      = decode_req(f_q.rx);
        commit_o    = 1'b0;
        f_d           = f_q;
        f_d.csn_prev  = csn_s;
        f_d.sclk_prev = sclk_s;
        if (cs_fall) begin
            f_d.in_frame = 1'b1;
            f_d.cnt      = '0;
            f_d.rx       = '0;
            f_d.armed    = 1'b0;
            f_d.sel      = REG_NONE;
        end else if (cs_rise && f_q.in_frame) begin
            f_d.in_frame = 1'b0;
            if (long_enough) begin
                commit_o  = 1'b1;
                f_d.armed = (dec_id != REG_NONE);
                f_d.sel   = dec_id;
            end
        end else if (sclk_fall && f_q.in_frame) begin
            if (!long_enough) begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
            if (f_q.cnt < CNT_W'(REQ_BITS)) begin
                f_d.rx = {f_q.rx[REQ_BITS-2:0], sdi_s};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.in_frame  <= 1'b0;
            f_q.csn_prev  <= 1'b1;
            f_q.sclk_prev <= 1'b1;
            f_q.cnt       <= '0;
            f_q.rx        <= '0;
            f_q.armed     <= 1'b0;
            f_q.sel       <= REG_NONE;
        end else begin
            f_q <= f_d;
        end
    end

    assign in_frame_o   = f_q.in_frame;
    assign sclk_fall_o  = sclk_fall & f_q.in_frame;
    assign start_o      = cs_fall;
    assign end_o        = cs_rise & f_q.in_frame;
    assign load_valid_o = f_q.armed;
    assign load_sel_o   = f_q.sel;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CNT_W'(MIN_EDGES));
    p_short_noarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && f_q.in_frame && !long_enough) |=> !f_q.armed);
    p_arm_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.armed) |-> $past(end_o));
    p_consume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !f_q.armed);
endmodule

// File: rtl/rbk_reg_bank.sv
module rbk_reg_bank
    import rbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_id_e          wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             commit,
    output logic [CFG_W-1:0] cfg_o,
    output logic [DAC_W-1:0] dac_a_o,
    output logic [DAC_W-1:0] dac_b_o
);
    typedef struct packed {
        logic [CFG_W-1:0] stg_cfg;
        logic [DAC_W-1:0] stg_a;
        logic [DAC_W-1:0] stg_b;
        logic [CFG_W-1:0] act_cfg;
        logic [DAC_W-1:0] act_a;
        logic [DAC_W-1:0] act_b;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (commit) begin
            b_d.act_cfg = b_q.stg_cfg;
            b_d.act_a   = b_q.stg_a;
            b_d.act_b   = b_q.stg_b;
        end
        if (wr_en) begin
            case (wr_sel)
                REG_CFG:  b_d.stg_cfg = wr_data;
                REG_DACA: b_d.stg_a   = wr_data[DAC_W-1:0];
                REG_DACB: b_d.stg_b   = wr_data[DAC_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign cfg_o   = b_q.act_cfg;
    assign dac_a_o = b_q.act_a;
    assign dac_b_o = b_q.act_b;

    p_hold_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(cfg_o) && $stable(dac_a_o) && $stable(dac_b_o)));
endmodule

// File: rtl/rbk_tx_shift.sv
module rbk_tx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              clear,
    output logic              sdo_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic              sdo;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.sh  = load_word;
            t_d.sdo = 1'b0;
        end else if (clear) begin
            t_d.sh  = '0;
            t_d.sdo = 1'b0;
        end else if (shift) begin
            t_d.sdo = t_q.sh[WORD_W-1];
            t_d.sh  = {t_q.sh[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign sdo_o = t_q.sdo;

    p_change_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load || clear || shift) |=> $stable(sdo_o));
    p_low_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !sdo_o);
endmodule

// File: rtl/rbk_serial_slave.sv
module rbk_serial_slave
    import rbk_pkg::*;
#(
    parameter int MIN_EDGES   = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_i,
    input  logic        csn_i,
    input  logic        sdi_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_sel_i,
    input  logic [11:0] wr_data_i,
    output logic        sdo_a_o,
    output logic        sdo_b_o
);
    logic [2:0]        pins_s;
    logic              in_frame, sclk_fall, start, fend, commit, load_valid;
    reg_id_e           load_sel;
    logic [CFG_W-1:0]  cfg;
    logic [DAC_W-1:0]  dac_a, dac_b;
    logic [WORD_W-1:0] load_word;

    rbk_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({csn_i, sclk_i, sdi_i}),
        .level_o (pins_s)
    );

    rbk_frame_ctrl #(.MIN_EDGES(MIN_EDGES), .REQ_BITS(WORD_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .csn_s        (pins_s[2]),
        .sclk_s       (pins_s[1]),
        .sdi_s        (pins_s[0]),
        .in_frame_o   (in_frame),
        .sclk_fall_o  (sclk_fall),
        .start_o      (start),
        .end_o        (fend),
        .commit_o     (commit),
        .load_valid_o (load_valid),
        .load_sel_o   (load_sel)
    );

    rbk_reg_bank bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_sel  (reg_id_e'(wr_sel_i)),
        .wr_data (wr_data_i),
        .commit  (commit),
        .cfg_o   (cfg),
        .dac_a_o (dac_a),
        .dac_b_o (dac_b)
    );

    always_comb begin
        load_word = load_valid ? fmt_word(load_sel, cfg, dac_a, dac_b) : '0;
    end

    rbk_tx_shift #(.WORD_W(WORD_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_word (load_word),
        .shift     (sclk_fall),
        .clear     (fend),
        .sdo_o     (sdo_a_o)
    );

    assign sdo_b_o = 1'b0;

    p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && !start) |-> !sdo_a_o);
endmodule

// File: tb/rbk_serial_slave_tb.sv
module rbk_serial_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        csn = 1'b1;
    logic        sdi = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [11:0] wr_data = 12'h000;
    logic        sdo_a, sdo_b;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    rbk_serial_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .csn_i     (csn),
        .sdi_i     (sdi),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .sdo_a_o   (sdo_a),
        .sdo_b_o   (sdo_b)
    );

    localparam int NV = 8;
    localparam logic [15:0] VREQ [NV] = '{16'h3000, 16'h1000, 16'h2000, 16'h3001,
                                          16'h4000, 16'h0000, 16'h3000, 16'h3000};
    localparam int          VEDG [NV] = '{48, 48, 48, 48, 48, 48, 47, 64};
    localparam logic [15:0] VEXP [NV] = '{16'h3A5C, 16'h1D98, 16'h27F8, 16'h0000,
                                          16'h0000, 16'h0000, 16'h0000, 16'h3A5C};

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] s, input logic [11:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_frame(input logic [15:0] req, input int edges,
                             input bit do_wr, input logic [1:0] ws, input logic [11:0] wv,
                             output logic [15:0] got, output bit tail_ok,
                             output bit b_ok, output bit idle_ok);
        got = '0; tail_ok = 1'b1; b_ok = 1'b1;
        @(negedge clk);
        csn = 1'b0;
        repeat (8) @(negedge clk);
        for (int k = 1; k <= edges; k++) begin
            sdi = (k <= 16) ? req[16-k] : 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (6) @(negedge clk);
            if (k <= 16) got[16-k] = sdo_a;
            else if (sdo_a !== 1'b0) tail_ok = 1'b0;
            if (sdo_b !== 1'b0) b_ok = 1'b0;
            if (do_wr && k == 20) write_reg(ws, wv);
            sclk = 1'b1;
            repeat (5) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        csn = 1'b1;
        repeat (12) @(negedge clk);
        idle_ok = (sdo_a === 1'b0) && (sdo_b === 1'b0);
    endtask

    task automatic pair(input logic [15:0] req, input int edges, input logic [15:0] exp,
                        input string tag);
        logic [15:0] g;
        bit t, b, i;
        run_frame(req, edges, 1'b0, 2'd0, 12'h0, g, t, b, i);
        run_frame(16'h0000, 48, 1'b0, 2'd0, 12'h0, g, t, b, i);
        check({tag, " word R1 R3"}, g, exp);
        check({tag, " tail zeros R3"}, {15'd0, t}, 16'd1);
        check({tag, " sdo_b low R4"}, {15'd0, b}, 16'd1);
        check({tag, " idle low R10"}, {15'd0, i}, 16'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] g;
        bit t, b, i;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("reset sdo_a R8", {15'd0, sdo_a}, 16'd0);
        check("reset sdo_b R4", {15'd0, sdo_b}, 16'd0);

        // R8: registers read back as zero before any write
        pair(16'h3000, 48, 16'h3000, "zero cfg R8 R5");
        pair(16'h2000, 48, 16'h2000, "zero dacB R8 R6");

        // preload then commit with one full frame
        write_reg(2'd0, 12'hA5C);
        write_reg(2'd1, 12'h1B3);
        write_reg(2'd2, 12'h0FF);
        write_reg(2'd3, 12'hFFF);
        run_frame(16'h0000, 48, 1'b0, 2'd0, 12'h0, g, t, b, i);

        // table: R1 decode, R2 length limit, R5/R6 formatting
        for (int n = 0; n < NV; n++) begin
            pair(VREQ[n], VEDG[n], VEXP[n], $sformatf("vec%0d R2 R5 R6", n));
        end

        // R9: a request is consumed after one frame
        run_frame(16'h3000, 48, 1'b0, 2'd0, 12'h0, g, t, b, i);
        run_frame(16'h0000, 48, 1'b0, 2'd0, 12'h0, g, t, b, i);
        check("first readback R9", g, 16'h3A5C);
        run_frame(16'h0000, 48, 1'b0, 2'd0, 12'h0, g, t, b, i);
        check("second frame empty R9", g, 16'h0000);

        // R7: write in request frame visible next frame; write in readback frame deferred
        run_frame(16'h1000, 48, 1'b1, 2'd1, 12'h155, g, t, b, i);
        run_frame(16'h0000, 48, 1'b1, 2'd1, 12'h0AA, g, t, b, i);
        check("write in request frame R7", g, 16'h1AA8);
        pair(16'h1000, 48, 16'h1550, "write in readback frame R7");

        // R2: short frame commits nothing; staged cfg shows only after a full frame
        write_reg(2'd0, 12'h123);
        run_frame(16'h3000, 47, 1'b0, 2'd0, 12'h0, g, t, b, i);
        run_frame(16'h0000, 48, 1'b0, 2'd0, 12'h0, g, t, b, i);
        check("short frame no readback R2", g, 16'h0000);
        pair(16'h3000, 48, 16'h3123, "staged cfg R7 R5");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule